// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Controller

This block is the receive front end for a demodulated infrared line. It brings the line through a synchronizer and measures every symbol as two durations. The first is the time the line spends low after a falling edge. The second is the time it then spends high, up to the next falling edge. Both durations are counted in coarse time ticks from a two-stage prescaler. The two counts are packed into one 32-bit word and queued in a small symbol FIFO, which software drains through a register port.

Software writes the configuration and turns the block on. It waits for the warm-up window to end and then writes the start register. The block raises interrupts in three cases: the FIFO has filled to a programmed level, a symbol timed out because the line stayed high too long, or a symbol was lost because the FIFO was full. Each cause has its own mask bit and its own clear bit.

A control state machine has three states. It steps DISABLED → WARMUP when enable is written with 1, and WARMUP → READY when the busy countdown expires. Writing enable with 0 returns it to DISABLED from any state.

The measuring state machine has five states:
- OFF: the state it holds while the control machine is DISABLED. A start accepted in READY moves it OFF → ARM.
- ARM → WAIT_FALL: the synchronized line is high.
- WAIT_FALL → LOW: a falling edge arrives.
- LOW → HIGH: a rising edge arrives.
- HIGH → LOW: a falling edge arrives. The symbol is pushed.
- HIGH → WAIT_FALL: the symbol span reaches the maximum width. The symbol is pushed and a timeout is flagged. If a falling edge arrives in that same cycle, the machine goes to LOW instead.

A start accepted in READY restarts the machine in ARM from any state.

Top module: `ir_pulse_capture`

## Requirements
- R1: After reset the register port reads as follows:
  - config (0x04) = 0x3E800080
  - mask (0x28) = 0x00000700
  - enable (0x00), busy (0x1C), count (0x20) and status (0x2C) = 0
  - irq is low
- R2: Writing 1 to bit 0 of enable (0x00) makes busy (0x1C) read 1 for BUSY_CYCLES cycles and then 0. A write to start (0x34) is ignored while the block is disabled or busy, and no symbol is captured after it.
- R3: A symbol opens at a falling edge of the line and closes at the next falling edge. Its word holds the low-phase tick count in bits [15:0] and the high-phase tick count in bits [31:16]. One tick lasts (config[6:0]+1)×TICK_DIV clock cycles.
- R4: Count (0x20) returns the number of stored symbols. Each read of data (0x24) returns the oldest symbol and removes it. A read of data with the FIFO empty returns 0 and leaves the count at 0.
- R5: In the high phase, once low+high reaches the maximum width in config[31:16], the symbol is pushed with its high count equal to the maximum minus the low count. Status bit 9 is then set, and the next symbol starts at the next falling edge.
- R6: Status bit 8 is set in every cycle in which count ≥ config[13:8]+1. A clear of bit 8 has no effect while that condition holds.
- R7: A symbol completed while the FIFO is full is dropped. Status bit 10 is set, and the stored symbols and the count are unchanged.
- R8: Writing clear (0x30) with bit 16, 17 or 18 clears status bit 8, 9 or 10 respectively. The other status bits keep their values.
- R9: Mask bits 8, 9 and 10 of register 0x28 each gate the status bit in the same position; a mask value of 0 enables. Status bits 24, 25 and 26 read as status bits 8, 9 and 10 ANDed with the inverted mask bits. irq is the OR of status bits 24 to 26.
- R10: The low and high tick counts saturate at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line, idle high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO on the data address) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from the address |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with the following parameters:

| Parameter | Value | What it brings within reach |
|---|---|---|
| TICK_DIV | 1 | With divisor field 3, one tick is four clocks, so table symbols and timeouts take a few dozen cycles. With divisor field 0, every clock is a tick, so the 0xFFFF saturation needs about 66,000 cycles. |
| FIFO_DEPTH | 4 | Overflow is reached with the fifth symbol. |
| BUSY_CYCLES | 6 | A start write can be placed inside the warm-up window. |

The maximum width is programmed to 20 ticks and the FIFO level field to 2. Timeout, the received threshold and its sticky clear behaviour are therefore all exercised within short symbol trains.

// File: rtl/ir_cap_pkg.sv
`timescale 1ns/1ps
package ir_cap_pkg;
    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] A_ENABLE = 8'h00;
    localparam logic [REG_AW-1:0] A_CONFIG = 8'h04;
    localparam logic [REG_AW-1:0] A_BUSY   = 8'h1C;
    localparam logic [REG_AW-1:0] A_COUNT  = 8'h20;
    localparam logic [REG_AW-1:0] A_DATA   = 8'h24;
    localparam logic [REG_AW-1:0] A_MASK   = 8'h28;
    localparam logic [REG_AW-1:0] A_STATUS = 8'h2C;
    localparam logic [REG_AW-1:0] A_CLEAR  = 8'h30;
    localparam logic [REG_AW-1:0] A_START  = 8'h34;

    localparam logic [31:0] CONFIG_RESET = 32'h3E80_0080;
    localparam logic [2:0]  MASK_RESET   = 3'b111;

    // status causes: index 0 received, 1 timeout, 2 overflow
    localparam int RAW_BASE  = 8;
    localparam int PEND_BASE = 24;
    localparam int CLR_BASE  = 16;

    localparam int CFG_MAXW_LSB  = 16;
    localparam int CFG_LEVEL_LSB = 8;
    localparam int CFG_DIV_W     = 7;

    typedef enum logic [1:0] {
        CS_DISABLED,
        CS_WARMUP,
        CS_READY
    } ctl_state_t;

    typedef enum logic [2:0] {
        MS_OFF,
        MS_ARM,
        MS_WAIT_FALL,
        MS_LOW,
        MS_HIGH
    } meter_state_t;
endpackage

// File: rtl/ir_tick_prescaler.sv
`timescale 1ns/1ps
module ir_tick_prescaler #(
    parameter int TICK_DIV = 10,
    parameter int DIV_W    = 7
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] us_div,
    output logic             tick
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(TICK_DIV - 1);

    logic [DIV_W-1:0] us_cnt;
    logic [TW-1:0]    t_cnt;
    logic             us_wrap;

    assign us_wrap = run && (us_cnt >= us_div);
    assign tick    = us_wrap && (t_cnt == T_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            us_cnt <= '0;
            t_cnt  <= '0;
        end else if (!run) begin
            us_cnt <= '0;
            t_cnt  <= '0;
        end else begin
            us_cnt <= us_wrap ? '0 : us_cnt + 1'b1;
            if (us_wrap)
                t_cnt <= (t_cnt == T_LAST) ? '0 : t_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ir_phase_meter.sv
`timescale 1ns/1ps
module ir_phase_meter
    import ir_cap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ir_raw,
    input  logic               hold_off,
    input  logic               arm,
    input  logic               tick,
    input  logic [CNT_W-1:0]   max_width,
    output logic               push,
    output logic [2*CNT_W-1:0] push_word,
    output logic               timeout_evt,
    output meter_state_t       state_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line, line_prev, fall, rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q    <= '1;
            line_prev <= 1'b1;
        end else begin
            sync_q    <= {sync_q[SYNC_STAGES-2:0], ir_raw};
            line_prev <= line;
        end
    end

    assign line = sync_q[SYNC_STAGES-1];
    assign fall = line_prev && !line;
    assign rise = !line_prev && line;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v, input logic en);
        return (en && (v != '1)) ? v + 1'b1 : v;
    endfunction

    meter_state_t     st_q, st_nx;
    logic [CNT_W-1:0] lo_q, hi_q, lo_nx, hi_nx, lo_inc, hi_inc;
    logic [CNT_W:0]   span;

    assign lo_inc = sat_inc(lo_q, tick);
    assign hi_inc = sat_inc(hi_q, tick);
    assign span   = {1'b0, lo_q} + {1'b0, hi_inc};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= MS_OFF;
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            st_q <= st_nx;
            lo_q <= lo_nx;
            hi_q <= hi_nx;
        end
    end

    always_comb begin
        st_nx       = st_q;
        lo_nx       = lo_q;
        hi_nx       = hi_q;
        push        = 1'b0;
        timeout_evt = 1'b0;
        push_word   = {hi_inc, lo_q};
        unique case (st_q)
            MS_OFF: ;
            MS_ARM: begin
                if (line)
                    st_nx = MS_WAIT_FALL;
            end
            MS_WAIT_FALL: begin
                if (fall) begin
                    st_nx = MS_LOW;
                    lo_nx = '0;
                    hi_nx = '0;
                end
            end
            MS_LOW: begin
                lo_nx = lo_inc;
                if (rise) begin
                    st_nx = MS_HIGH;
                    hi_nx = '0;
                end
            end
            MS_HIGH: begin
                hi_nx = hi_inc;
                if (span >= {1'b0, max_width}) begin
                    push        = 1'b1;
                    timeout_evt = 1'b1;
                    st_nx       = fall ? MS_LOW : MS_WAIT_FALL;
                    lo_nx       = '0;
                    hi_nx       = '0;
                end else if (fall) begin
                    push  = 1'b1;
                    st_nx = MS_LOW;
                    lo_nx = '0;
                    hi_nx = '0;
                end
            end
            default: st_nx = MS_OFF;
        endcase
        if (hold_off || arm) begin
            st_nx       = hold_off ? MS_OFF : MS_ARM;
            lo_nx       = '0;
            hi_nx       = '0;
            push        = 1'b0;
            timeout_evt = 1'b0;
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/ir_symbol_fifo.sv
`timescale 1ns/1ps
module ir_symbol_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] P_LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push;
    assign rdata   = (count != '0) ? mem[rd_ptr] : '0;

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == P_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == P_LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/ir_pulse_capture.sv
`timescale 1ns/1ps
module ir_pulse_capture
    import ir_cap_pkg::*;
#(
    parameter int TICK_DIV    = 10,
    parameter int FIFO_DEPTH  = 8,
    parameter int BUSY_CYCLES = 16,
    parameter int SYNC_STAGES = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 16;
    localparam int FCW   = $clog2(FIFO_DEPTH + 1);
    localparam int BCW   = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;

    // ---------------- register decode
    logic wr_enable, wr_config, wr_mask, wr_clear, wr_start, rd_data;
    assign wr_enable = bus_wr && (bus_addr == A_ENABLE);
    assign wr_config = bus_wr && (bus_addr == A_CONFIG);
    assign wr_mask   = bus_wr && (bus_addr == A_MASK);
    assign wr_clear  = bus_wr && (bus_addr == A_CLEAR);
    assign wr_start  = bus_wr && (bus_addr == A_START);
    assign rd_data   = bus_rd && (bus_addr == A_DATA);

    // ---------------- control state machine
    ctl_state_t     ctl_q, ctl_nx;
    logic [BCW-1:0] busy_q, busy_nx;
    logic           busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= CS_DISABLED;
            busy_q <= '0;
        end else begin
            ctl_q  <= ctl_nx;
            busy_q <= busy_nx;
        end
    end

    always_comb begin
        ctl_nx  = ctl_q;
        busy_nx = busy_q;
        unique case (ctl_q)
            CS_DISABLED: begin
                if (wr_enable && bus_wdata[0]) begin
                    ctl_nx  = CS_WARMUP;
                    busy_nx = BCW'(BUSY_CYCLES - 1);
                end
            end
            CS_WARMUP: begin
                if (busy_q == '0)
                    ctl_nx = CS_READY;
                else
                    busy_nx = busy_q - 1'b1;
            end
            CS_READY: ;
            default: ctl_nx = CS_DISABLED;
        endcase
        if (wr_enable && !bus_wdata[0]) begin
            ctl_nx  = CS_DISABLED;
            busy_nx = '0;
        end
    end

    assign busy = (ctl_q == CS_WARMUP);

    // ---------------- configuration and mask
    logic [31:0] cfg_q;
    logic [2:0]  mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= CONFIG_RESET;
            mask_q <= MASK_RESET;
        end else begin
            if (wr_config)
                cfg_q <= bus_wdata;
            if (wr_mask)
                mask_q <= bus_wdata[RAW_BASE +: 3];
        end
    end

    // ---------------- datapath
    logic                 tick;
    logic                 sym_push, tmo_evt;
    logic [2*CNT_W-1:0]   sym_word;
    meter_state_t         meter_state;
    logic [FCW-1:0]       fifo_count;
    logic [2*CNT_W-1:0]   fifo_head;
    logic                 fifo_drop;
    logic                 fifo_push, fifo_pop;

    ir_tick_prescaler #(
        .TICK_DIV (TICK_DIV),
        .DIV_W    (CFG_DIV_W)
    ) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctl_q != CS_DISABLED),
        .us_div (cfg_q[CFG_DIV_W-1:0]),
        .tick   (tick)
    );

    ir_phase_meter #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .ir_raw      (ir_in),
        .hold_off    (ctl_q == CS_DISABLED),
        .arm         (wr_start && (ctl_q == CS_READY)),
        .tick        (tick),
        .max_width   (cfg_q[CFG_MAXW_LSB +: CNT_W]),
        .push        (sym_push),
        .push_word   (sym_word),
        .timeout_evt (tmo_evt),
        .state_o     (meter_state)
    );

    assign fifo_push = sym_push;
    assign fifo_pop  = rd_data;

    ir_symbol_fifo #(
        .WIDTH (2*CNT_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .wdata (sym_word),
        .pop   (fifo_pop),
        .rdata (fifo_head),
        .count (fifo_count),
        .drop  (fifo_drop)
    );

    // ---------------- interrupt status
    logic [2:0]  status_q, clr_bits, set_bits;
    logic [6:0]  level_thr;
    logic        rcv_cond;

    assign level_thr = {1'b0, cfg_q[CFG_LEVEL_LSB +: 6]} + 7'd1;
    assign rcv_cond  = 32'(fifo_count) >= 32'(level_thr);
    assign clr_bits  = wr_clear ? bus_wdata[CLR_BASE +: 3] : 3'b000;
    assign set_bits  = {fifo_drop, tmo_evt, rcv_cond};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr_bits) | set_bits;
    end

    assign irq = |(status_q & ~mask_q);

    // ---------------- read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ENABLE: bus_rdata[0] = (ctl_q != CS_DISABLED);
            A_CONFIG: bus_rdata = cfg_q;
            A_BUSY:   bus_rdata[0] = busy;
            A_COUNT:  bus_rdata = 32'(fifo_count);
            A_DATA:   bus_rdata = fifo_head;
            A_MASK:   bus_rdata[RAW_BASE +: 3] = mask_q;
            A_STATUS: begin
                bus_rdata[RAW_BASE +: 3]  = status_q;
                bus_rdata[PEND_BASE +: 3] = status_q & ~mask_q;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ir_pulse_capture_checker.sv
`timescale 1ns/1ps
module ir_pulse_capture_checker
    import ir_cap_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4
)(
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] fifo_count,
    input logic          fifo_push,
    input logic          fifo_pop,
    input logic          fifo_drop,
    input logic          busy,
    input meter_state_t  meter_state,
    input logic          tmo_evt,
    input logic [2:0]    status_q,
    input logic [2:0]    mask_q,
    input logic          irq
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fifo_count) <= DEPTH); // R4

    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && !fifo_push && fifo_count != '0) |=> fifo_count == CW'($past(fifo_count) - 1'b1)); // R4

    AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_drop |=> fifo_count == $past(fifo_count)); // R7

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_drop |=> status_q[2]); // R7

    AST_TIMEOUT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt |=> status_q[1]); // R5

    AST_WARMUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> meter_state == MS_OFF); // R2

    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 3'b111) |-> !irq); // R9
endmodule

bind ir_pulse_capture ir_pulse_capture_checker #(
    .DEPTH (FIFO_DEPTH),
    .CW    ($clog2(FIFO_DEPTH + 1))
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_count  (fifo_count),
    .fifo_push   (fifo_push),
    .fifo_pop    (fifo_pop),
    .fifo_drop   (fifo_drop),
    .busy        (busy),
    .meter_state (meter_state),
    .tmo_evt     (tmo_evt),
    .status_q    (status_q),
    .mask_q      (mask_q),
    .irq         (irq)
);

// File: tb/test_ir_pulse_capture.sv
`timescale 1ns/1ps
module test_ir_pulse_capture;
    localparam int TP = 4; // clocks per tick with divisor field 3 and TICK_DIV 1
    localparam logic [31:0] CFG_MAIN = 32'h0014_0283; // maxw 20, level 2, raw, div 3
    localparam logic [31:0] CFG_FAST = 32'h0014_0280; // same with div 0
    // table: {high ticks, low ticks}, also the expected FIFO word
    localparam logic [31:0] VEC [3] = '{32'h0005_0003, 32'h0001_0001, 32'h000A_0007};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    ir_pulse_capture #(
        .TICK_DIV    (1),
        .FIFO_DEPTH  (4),
        .BUSY_CYCLES (6),
        .SYNC_STAGES (2)
    ) i_ir_pulse_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_in     (ir_in),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // starts and ends on a negedge; samples one time unit after it
    task automatic rd(input logic [7:0] a);
        bus_rd = 1'b1; bus_addr = a;
        #1 rv = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic line(input logic v, input int cycles);
        ir_in = v;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h04); check("R1 config", rv, 32'h3E80_0080);
        rd(8'h28); check("R1 mask", rv, 32'h0000_0700);
        rd(8'h00); check("R1 enable", rv, 32'h0);
        rd(8'h1C); check("R1 busy", rv, 32'h0);
        rd(8'h20); check("R1 count", rv, 32'h0);
        rd(8'h2C); check("R1 status", rv, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 start ignored while disabled
        wr(8'h04, CFG_MAIN);
        wr(8'h34, 32'h1);
        @(negedge clk);
        line(0, 3*TP); line(1, 3*TP); line(0, 3*TP); line(1, 100);
        rd(8'h20); check("R2 start while disabled", rv, 32'h0);

        // R2 busy window and start ignored while busy
        wr(8'h00, 32'h1);
        rd(8'h1C); check("R2 busy after enable", rv, 32'h1);
        wr(8'h34, 32'h1);
        repeat (10) @(negedge clk);
        rd(8'h1C); check("R2 busy expired", rv, 32'h0);
        line(0, 3*TP); line(1, 3*TP); line(0, 3*TP); line(1, 100);
        rd(8'h20); check("R2 start while busy", rv, 32'h0);

        wr(8'h34, 32'h1);
        repeat (6) @(negedge clk);

        // R3 R6 table of symbols, count and level checked inside each high phase
        for (int i = 0; i < 3; i++) begin
            fork
                begin
                    line(0, int'(VEC[i][15:0]) * TP);
                    line(1, int'(VEC[i][31:16]) * TP);
                end
                begin
                    repeat (int'(VEC[i][15:0]) * TP + 1) @(negedge clk);
                    rd(8'h20); check("R3 count during high", rv, 32'(i));
                    rd(8'h2C); check("R6 below level", rv & 32'h100, 32'h0);
                end
            join
        end
        line(0, 5*TP);   // closes the last table symbol
        line(1, 100);    // times out at high = 20 - 5

        rd(8'h20); check("R4 count", rv, 32'd4);
        rd(8'h2C); check("R5 R6 raw status masked", rv, 32'h0000_0300);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h28, 32'h0);
        @(negedge clk);
        rd(8'h2C); check("R9 pending bits", rv, 32'h0300_0300);
        check("R9 irq unmasked", {31'b0, irq}, 32'h1);
        wr(8'h30, 32'h0003_0000);
        @(negedge clk);
        rd(8'h2C); check("R8 R6 clear timeout, level holds", rv, 32'h0100_0100);

        for (int i = 0; i < 3; i++) begin
            rd(8'h24); check("R3 popped symbol", rv, VEC[i]);
        end
        rd(8'h24); check("R5 timeout symbol", rv, 32'h000F_0005);
        rd(8'h24); check("R4 empty read", rv, 32'h0);
        rd(8'h20); check("R4 count after drain", rv, 32'h0);
        rd(8'h2C); check("R6 sticky after drain", rv, 32'h0100_0100);
        wr(8'h30, 32'h0001_0000);
        @(negedge clk);
        rd(8'h2C); check("R8 clear received", rv, 32'h0);
        check("R8 irq low", {31'b0, irq}, 32'h0);

        // R7 overflow: four fit, the fifth is dropped
        for (int k = 1; k <= 4; k++) begin
            line(0, k*TP); line(1, 2*TP);
        end
        line(0, 6*TP);
        line(1, 100);
        rd(8'h20); check("R7 count full", rv, 32'd4);
        rd(8'h2C); check("R7 overflow status", rv, 32'h0700_0700);
        check("R7 irq", {31'b0, irq}, 32'h1);
        rd(8'h24); check("R7 oldest kept", rv, 32'h0002_0001);
        rd(8'h24); rd(8'h24);
        rd(8'h24); check("R7 newest kept, dropped absent", rv, 32'h0002_0004);
        rd(8'h20); check("R7 drained", rv, 32'h0);
        wr(8'h30, 32'h0007_0000);
        @(negedge clk);
        rd(8'h2C); check("R8 clear all", rv, 32'h0);

        // R10 saturation with one tick per clock
        wr(8'h04, CFG_FAST);
        line(0, 66000);
        line(1, 50);
        rd(8'h20); check("R10 count", rv, 32'd1);
        rd(8'h24); check("R10 saturated low", rv, 32'h0001_FFFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule